// File: doc/BRIEF.md
# Two-Way Cache Line Replacement Status Tracker

This block keeps one 2-bit status code for every line of a two-way set-associative cache. A single code holds both the validity of the two ways and, once both are valid, which way was touched last. The cache controller presents a line index together with a hit strobe (and the way that hit) or a miss strobe. The block reads the addressed entry combinationally and reports its code, the per-way valid flags and the way a fill should go to. On the next clock edge it writes the new code for that line.

Fills always go to way 0 first and then to way 1. After both ways are valid, the way that was not used most recently is replaced. Tag storage and data movement belong to the surrounding cache and are not handled here. The entry count is set by a size parameter: 128 lines for the larger cache and 64 for the smaller one.

Top module: `lru_line_tracker`

## Requirements
- R1: A synchronous reset sets every entry to code 00. After reset, every index reads cur_code 00, way_valid 00 and fill_way 0.
- R2: way_valid bit 0 is 1 for codes 01, 10 and 11. way_valid bit 1 is 1 for codes 10 and 11.
- R3: fill_way is 0 for code 00, 1 for code 01, 0 for code 11 and 1 for code 10.
- R4: A miss on a line in code 00 moves it to 01. A miss on a line in code 01 moves it to 11.
- R5: A miss on a line in code 11 moves it to 10. A miss on a line in code 10 moves it to 11.
- R6: A hit on a line in code 00 or 01 leaves its code unchanged.
- R7: In code 11, a hit on way 0 (hit_way=0) moves the line to 10 and a hit on way 1 keeps it at 11. In code 10, a hit on way 1 moves the line to 11 and a hit on way 0 keeps it at 10.
- R8: Only the entry selected by line_idx changes on a strobe edge. With neither strobe asserted, no entry changes.
- R9: When hit_stb and miss_stb are both asserted, the update follows the miss rule.
- R10: cur_code is a combinational read of the stored entry. A change made at a clock edge is visible on cur_code after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears every entry |
| line_idx | input | IDX_W | Index of the addressed cache line |
| hit_stb | input | 1 | Lookup hit on the addressed line |
| hit_way | input | 1 | Way that hit (0 or 1) |
| miss_stb | input | 1 | Lookup miss on the addressed line |
| cur_code | output | 2 | Stored status code of the addressed line |
| way_valid | output | 2 | Valid flag per way of the addressed line (bit i = way i) |
| fill_way | output | 1 | Way to fill on a miss for the addressed line |

## Verification
The embedded assertions check on every cycle that:
- a write lands in exactly the addressed entry;
- every other entry holds its value;
- a miss always makes the chosen fill way valid;
- a hit never changes how many ways are valid;
- the fill way never points past the valid ways.

The transition rule itself (R4, R5, R6, R7, R9), the reset sweep (R1) and the decoding of each code (R2, R3) can only be shown by the bench. The bench runs long mixed strobe sequences against its own valid/most-recent model of every line and rescans the whole array at intervals.

// File: rtl/lru_pkg.sv
package lru_pkg;
  localparam logic [1:0] CODE_EMPTY  = 2'b00;
  localparam logic [1:0] CODE_W0     = 2'b01;
  localparam logic [1:0] CODE_MRU_W1 = 2'b11;
  localparam logic [1:0] CODE_MRU_W0 = 2'b10;

  // valid flags per way, bit i = way i
  function automatic logic [1:0] code_valid(input logic [1:0] c);
    code_valid = {c[1], (c != CODE_EMPTY)};
  endfunction

  // way a miss would fill
  function automatic logic code_victim(input logic [1:0] c);
    code_victim = (c == CODE_W0) || (c == CODE_MRU_W0);
  endfunction

  // transition rule; miss dominates a simultaneous hit
  function automatic logic [1:0] code_step(input logic [1:0] c, input logic hit,
                                           input logic hway, input logic miss);
    logic [1:0] n;
    n = c;
    if (miss) begin
      case (c)
        CODE_EMPTY:  n = CODE_W0;
        CODE_W0:     n = CODE_MRU_W1;
        CODE_MRU_W1: n = CODE_MRU_W0;
        default:     n = CODE_MRU_W1;
      endcase
    end else if (hit) begin
      case (c)
        CODE_MRU_W1: n = hway ? CODE_MRU_W1 : CODE_MRU_W0;
        CODE_MRU_W0: n = hway ? CODE_MRU_W1 : CODE_MRU_W0;
        default:     n = c;
      endcase
    end
    code_step = n;
  endfunction
endpackage

// File: rtl/lru_step_logic.sv
module lru_step_logic
  import lru_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cur,
  input  logic       hit,
  input  logic       hway,
  input  logic       miss,
  output logic [1:0] nxt,
  output logic       upd,
  output logic       victim,
  output logic [1:0] valid_now
);
  logic [1:0] valid_nxt;

  always_comb begin
    nxt       = code_step(cur, hit, hway, miss);
    upd       = hit | miss;
    victim    = code_victim(cur);
    valid_now = code_valid(cur);
    valid_nxt = code_valid(nxt);
  end

  // R4 R5: the way chosen for the fill is valid afterwards
  fill_makes_valid_chk: assert property (@(posedge clk) disable iff (rst)
    miss |-> valid_nxt[victim]);

  // R6 R7: a hit alone never changes the valid count
  hit_keeps_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !miss) |-> ($countones(valid_nxt) == $countones(valid_now)));

  // R3: fill target of way 1 only once way 0 is valid
  victim_order_chk: assert property (@(posedge clk) disable iff (rst)
    victim |-> valid_now[0]);
endmodule

// File: rtl/lru_state_store.sv
module lru_state_store #(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_en,
  input  logic [1:0]       wr_code,
  output logic [1:0]       rd_code
);
  logic [1:0] entry [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) entry[i] <= 2'b00;
    end else if (wr_en) begin
      entry[idx] <= wr_code;
    end
  end

  assign rd_code = entry[idx];

  // R8 R10: the addressed entry takes the written code
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (entry[$past(idx)] == $past(wr_code)));

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_hold
      // R8: entries not addressed keep their value
      other_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (idx == IDX_W'(g))) |=> $stable(entry[g]));
    end
  endgenerate
endmodule

// File: rtl/lru_line_tracker.sv
module lru_line_tracker #(
  parameter bit SIZE_LARGE = 1'b1,
  parameter int LINES_LARGE = 128,
  localparam int DEPTH = SIZE_LARGE ? LINES_LARGE : LINES_LARGE / 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] line_idx,
  input  logic             hit_stb,
  input  logic             hit_way,
  input  logic             miss_stb,
  output logic [1:0]       cur_code,
  output logic [1:0]       way_valid,
  output logic             fill_way
);
  logic [1:0] rd_code;
  logic [1:0] nxt_code;
  logic       upd_en;

  lru_state_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .idx(line_idx),
    .wr_en(upd_en), .wr_code(nxt_code), .rd_code(rd_code)
  );

  lru_step_logic step_i (
    .clk(clk), .rst(rst), .cur(rd_code),
    .hit(hit_stb), .hway(hit_way), .miss(miss_stb),
    .nxt(nxt_code), .upd(upd_en), .victim(fill_way), .valid_now(way_valid)
  );

  assign cur_code = rd_code;

  // R2: way 1 is never valid without way 0
  valid_order_chk: assert property (@(posedge clk) disable iff (rst)
    way_valid[1] |-> way_valid[0]);
endmodule

// File: tb/lru_line_tracker_tb_top.sv
module lru_line_tracker_tb_top;
  localparam int N = 128;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] line_idx = '0;
  logic hit_stb = 1'b0, hit_way = 1'b0, miss_stb = 1'b0;
  logic [1:0] cur_code, way_valid;
  logic fill_way;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit v0 [N];
  bit v1 [N];
  bit mru [N];

  always #10 clk = ~clk;

  lru_line_tracker dut_i (
    .clk(clk), .rst(rst), .line_idx(line_idx), .hit_stb(hit_stb),
    .hit_way(hit_way), .miss_stb(miss_stb), .cur_code(cur_code),
    .way_valid(way_valid), .fill_way(fill_way)
  );

  function automatic logic [1:0] exp_code(input int i);
    if (!v0[i]) return 2'b00;
    if (!v1[i]) return 2'b01;
    return mru[i] ? 2'b11 : 2'b10;
  endfunction

  function automatic logic exp_fill(input int i);
    if (!v0[i]) return 1'b0;
    if (!v1[i]) return 1'b1;
    return ~mru[i];
  endfunction

  task automatic clear_model();
    for (int i = 0; i < N; i++) begin v0[i] = 0; v1[i] = 0; mru[i] = 0; end
  endtask

  task automatic check_line(input int i, input string tag);
    logic [1:0] ec, ev;
    logic ef;
    line_idx = 7'(i);
    #1;
    ec = exp_code(i); ev = {v1[i], v0[i]}; ef = exp_fill(i);
    checks++;
    if (cur_code !== ec || way_valid !== ev || fill_way !== ef) begin
      errors++;
      $display("FAIL %s line %0d: code/valid/fill act %b/%b/%b exp %b/%b/%b",
               tag, i, cur_code, way_valid, fill_way, ec, ev, ef);
    end
  endtask

  task automatic scan_all(input string tag);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      check_line(i, tag);
    end
  endtask

  task automatic do_op(input int i, input bit h, input bit hw, input bit m);
    @(negedge clk);
    line_idx = 7'(i); hit_stb = h; hit_way = hw; miss_stb = m;
    #1;
    check_line(i, "R10 R2 R3 pre-update");
    @(negedge clk);
    hit_stb = 0; miss_stb = 0;
    if (m) begin
      if (!v0[i]) v0[i] = 1;
      else if (!v1[i]) begin v1[i] = 1; mru[i] = 1; end
      else mru[i] = ~mru[i];
    end else if (h) begin
      if (v0[i] && v1[i]) mru[i] = hw;
    end
    check_line(i, m ? (h ? "R9 R4 R5" : "R4 R5") :
                  (h ? "R6 R7" : "R8 idle"));
  endtask

  initial begin
    bit [15:0] lfsr;
    int idx;
    clear_model();
    repeat (3) @(negedge clk);
    rst = 0;
    scan_all("R1");
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      idx = (lfsr[2:0] == 3'd7) ? 127 : int'(lfsr[3:0] & 4'h7);
      do_op(idx, lfsr[8] | lfsr[9], lfsr[10], lfsr[11] & ~lfsr[12]);
      if (k % 1000 == 999) scan_all("R8");
    end
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    clear_model();
    scan_all("R1 after reset");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule